// File: doc/BRIEF.md
# Programmable Duty Channel Divider

This block turns a fast input clock into a slower channel clock. The high time and the low time of the output are set by two separate 4-bit counts, so both the ratio and the duty cycle can be chosen. Each phase lasts its count plus one input cycle, and the total ratio therefore runs from 2 to 32. A bypass path gives a ratio of 1 by passing the input clock straight to the output and stopping the counter.

A synchronization request realigns the channel. The request may arrive from another clock domain, so a short flop chain first brings it into the fast domain. While the request is held, the output stays at a static level. When the request is released, counting restarts. A programmable offset delays the first edge. A start-level bit picks which phase comes first. A force-high bit chooses the static level. An ignore bit lets the channel run straight through a request. A power-down input stops the divider. An optional correction stretches the high phase by half an input cycle when the total ratio is odd.

The controller is a five-state machine. ST_IDLE means stopped by power-down or bypass. ST_HOLD means held by a request, and it is also the state the block enters at reset. ST_WAIT is the offset countdown. ST_HIGH and ST_LOW are the two running phases. Its transitions are:
- halt: any state moves to ST_IDLE.
- hold: any state moves to ST_HOLD on an unmasked request.
- launch: ST_IDLE or ST_HOLD moves to ST_WAIT, or directly to the first phase when the offset is zero.
- open: ST_WAIT moves to the first phase once its count is used up.
- toggle: ST_HIGH and ST_LOW alternate whenever the phase count reaches zero.

Top module: `chan_divider`

## Requirements
- R1: With cfg_hi_cnt = h and cfg_lo_cnt = l (each 4 bits, 0 to 15), the running output is high for h+1 input cycles and low for l+1 input cycles, so the period is h+l+2 cycles.
- R2: After a launch with zero offset, the output enters the high phase first when cfg_start_high = 1 and the low phase first when it is 0. The new level is visible after the launching rising edge.
- R3: With cfg_phase = p, the first phase begins p input cycles after the launching edge. Until then the output sits at the cfg_force_high level.
- R4: sync_req passes through a two-flop synchronizer. While it is held, the output is static at the cfg_force_high level. If it is dropped before rising edge j, the launch happens on edge j+2.
- R5: While cfg_ignore_sync = 1, sync_req has no effect: the output keeps its running pattern without a break.
- R6: While cfg_power_down = 1, the output is static at the cfg_force_high level, and it follows a change of that level. If power-down is dropped before edge j, the launch happens on edge j.
- R7: While cfg_bypass = 1, clk_out equals clk_in. When bypass is dropped, the divider launches as in R6.
- R8: With cfg_dcc_en = 1 and h+l+2 odd, the high phase is stretched by half an input cycle. With an even ratio, or with the correction off, the duty is unchanged.
- R9: While rst_n = 0 and bypass is off, clk_out is low. After reset is released, the first rising edge launches the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Asynchronous realignment request, active high |
| cfg_hi_cnt | input | 4 | High phase length minus one |
| cfg_lo_cnt | input | 4 | Low phase length minus one |
| cfg_phase | input | 4 | Input cycles to wait before the first phase after launch |
| cfg_start_high | input | 1 | 1: begin with the high phase; 0: begin with the low phase |
| cfg_force_high | input | 1 | Static output level while stopped, held or waiting |
| cfg_ignore_sync | input | 1 | Makes the channel ignore sync_req |
| cfg_bypass | input | 1 | Route clk_in to clk_out and stop the divider |
| cfg_power_down | input | 1 | Stop the divider |
| cfg_dcc_en | input | 1 | Enable the half-cycle stretch for odd ratios |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest situation to reach is exact edge placement after realignment. The request goes through the synchronizer and then the offset countdown, so the first edge moves by several cycles that depend on the setup. The bench drops the request on a known falling edge and counts the synchronizer latency into its expected pattern. It then sweeps all 256 high/low count pairs and every offset with both start levels, and compares every cycle against an arithmetic model. The half-cycle stretch is reached by sampling a quarter cycle after each clock edge and counting high samples over whole periods.

// File: rtl/chan_divider_pkg.sv
package chan_divider_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT,
        ST_HIGH,
        ST_LOW
    } div_state_e;
endpackage

// File: rtl/chan_divider_sync.sv
module chan_divider_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (STAGES < 2) begin : g_single
            logic flop_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flop_q <= 1'b0;
                else        flop_q <= async_in;
            end
            assign sync_out = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
            assign sync_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/chan_divider_fsm.sv
module chan_divider_fsm
    import chan_divider_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             sync_hit,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] phase,
    input  logic             start_high,
    input  logic             force_high,
    output div_state_e       state_o,
    output logic             lvl_o
);
    div_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (halt) begin
            state_n = ST_IDLE;                       // halt
        end else if (sync_hit) begin
            state_n = ST_HOLD;                       // hold
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: begin              // launch
                    if (phase != '0) begin
                        state_n = ST_WAIT;
                        cnt_n   = phase - CNT_W'(1);
                    end else if (start_high) begin
                        state_n = ST_HIGH;
                        cnt_n   = hi_cnt;
                    end else begin
                        state_n = ST_LOW;
                        cnt_n   = lo_cnt;
                    end
                end
                ST_WAIT: begin                       // open
                    if (cnt_q == '0) begin
                        if (start_high) begin
                            state_n = ST_HIGH;
                            cnt_n   = hi_cnt;
                        end else begin
                            state_n = ST_LOW;
                            cnt_n   = lo_cnt;
                        end
                    end else begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end
                end
                ST_HIGH: begin                       // toggle
                    if (cnt_q == '0) begin
                        state_n = ST_LOW;
                        cnt_n   = lo_cnt;
                    end else begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end
                end
                ST_LOW: begin                        // toggle
                    if (cnt_q == '0) begin
                        state_n = ST_HIGH;
                        cnt_n   = hi_cnt;
                    end else begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    state_n = ST_HOLD;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // Output level, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
        end else begin
            unique case (state_n)
                ST_HIGH: lvl_o <= 1'b1;
                ST_LOW:  lvl_o <= 1'b0;
                default: lvl_o <= force_high;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/chan_divider_out.sv
module chan_divider_out (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic dcc_act,
    input  logic bypass,
    output logic clk_out
);
    logic stretch_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) stretch_q <= 1'b0;
        else        stretch_q <= lvl;
    end

    assign clk_out = bypass ? clk : (lvl | (dcc_act & stretch_q));
endmodule

// File: rtl/chan_divider.sv
module chan_divider
    import chan_divider_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             sync_req,
    input  logic [CNT_W-1:0] cfg_hi_cnt,
    input  logic [CNT_W-1:0] cfg_lo_cnt,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             cfg_start_high,
    input  logic             cfg_force_high,
    input  logic             cfg_ignore_sync,
    input  logic             cfg_bypass,
    input  logic             cfg_power_down,
    input  logic             cfg_dcc_en,
    output logic             clk_out
);
    logic       sync_s;
    logic       halt;
    logic       div_lvl;
    logic       dcc_act;
    div_state_e fsm_state;

    assign halt    = cfg_power_down | cfg_bypass;
    assign dcc_act = cfg_dcc_en & (cfg_hi_cnt[0] ^ cfg_lo_cnt[0]);

    chan_divider_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .async_in (sync_req),
        .sync_out (sync_s)
    );

    chan_divider_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .halt       (halt),
        .sync_hit   (sync_s & ~cfg_ignore_sync),
        .hi_cnt     (cfg_hi_cnt),
        .lo_cnt     (cfg_lo_cnt),
        .phase      (cfg_phase),
        .start_high (cfg_start_high),
        .force_high (cfg_force_high),
        .state_o    (fsm_state),
        .lvl_o      (div_lvl)
    );

    chan_divider_out u_out (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .lvl     (div_lvl),
        .dcc_act (dcc_act),
        .bypass  (cfg_bypass),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/chan_divider_chk.sv
module chan_divider_chk
    import chan_divider_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input div_state_e       state,
    input logic             sync_s,
    input logic             halt,
    input logic             ign,
    input logic             force_hi,
    input logic             lvl,
    input logic [CNT_W-1:0] cfg_hi,
    input logic [CNT_W-1:0] cfg_lo
);
    div_state_e       prev_state;
    logic [CNT_W-1:0] hi_d, lo_d, hi_lim, lo_lim;
    logic [CNT_W:0]   hi_run, lo_run;
    logic             hi_ok, lo_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_state <= ST_HOLD;
            hi_d <= '0; lo_d <= '0; hi_lim <= '0; lo_lim <= '0;
            hi_run <= '0; lo_run <= '0; hi_ok <= 1'b0; lo_ok <= 1'b0;
        end else begin
            prev_state <= state;
            hi_d <= cfg_hi;
            lo_d <= cfg_lo;
            if (state == ST_HIGH) begin
                if (prev_state != ST_HIGH) begin
                    hi_run <= 1; hi_lim <= hi_d; hi_ok <= 1'b1;
                end else begin
                    hi_run <= hi_run + 1'b1;
                end
            end
            if (state == ST_LOW) begin
                if (prev_state != ST_LOW) begin
                    lo_run <= 1; lo_lim <= lo_d; lo_ok <= 1'b1;
                end else begin
                    lo_run <= lo_run + 1'b1;
                end
            end
        end
    end

    assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && prev_state == ST_HIGH && hi_ok) |-> hi_run == {1'b0, hi_lim} + 1'b1);

    assert_low_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && prev_state == ST_LOW && lo_ok) |-> lo_run == {1'b0, lo_lim} + 1'b1);

    assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_s) && !$past(ign) && !$past(halt)) |-> state == ST_HOLD);

    assert_ignore_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ign) && $past(state) != ST_HOLD) |-> state != ST_HOLD);

    assert_halt_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> lvl == $past(force_hi));
endmodule

bind chan_divider chan_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .sync_s   (sync_s),
    .halt     (halt),
    .ign      (cfg_ignore_sync),
    .force_hi (cfg_force_high),
    .lvl      (div_lvl),
    .cfg_hi   (cfg_hi_cnt),
    .cfg_lo   (cfg_lo_cnt)
);

// File: tb/chan_divider_bench.sv
`timescale 1ns/1ps
module chan_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_req;
    logic [3:0] hi, lo, ph;
    logic       sh, fh, ign, byp, pd, dcc;
    logic       clk_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    chan_divider u_chan_divider (
        .clk_in (clk), .rst_n (rst_n), .sync_req (sync_req),
        .cfg_hi_cnt (hi), .cfg_lo_cnt (lo), .cfg_phase (ph),
        .cfg_start_high (sh), .cfg_force_high (fh),
        .cfg_ignore_sync (ign), .cfg_bypass (byp),
        .cfg_power_down (pd), .cfg_dcc_en (dcc),
        .clk_out (clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (hi=%0d lo=%0d ph=%0d sh=%0d fh=%0d) t=%0t",
                     req, act, exp, hi, lo, ph, sh, fh, $time);
        end
    endtask

    function automatic logic exp_lvl(input int n);
        int t, h, l, q;
        h = int'(hi) + 1;
        l = int'(lo) + 1;
        t = n - int'(ph);
        if (t < 0) return fh;
        q = t % (h + l);
        if (sh) return logic'(q < h);
        return logic'(q >= l);
    endfunction

    // Pulse the request and check the hold level; return aligned so the next negedge is n = 0.
    task automatic sync_pulse();
        @(negedge clk) sync_req = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 hold level", int'(clk_out), int'(fh));
        sync_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_check(input string req, input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            check(req, int'(clk_out), int'(exp_lvl(n)));
        end
    endtask

    initial begin
        rst_n = 1'b0; sync_req = 1'b0;
        hi = 4'd1; lo = 4'd1; ph = 4'd0; sh = 1'b1; fh = 1'b1;
        ign = 1'b0; byp = 1'b0; pd = 1'b0; dcc = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R9 reset low", int'(clk_out), 0);
        end
        rst_n = 1'b1;
        run_check("R9 launch after reset", 12);

        // R1: full sweep of both counts
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                hi = 4'(a); lo = 4'(b); ph = 4'd0; sh = a[0]; fh = b[0];
                sync_pulse();
                run_check("R1 phase lengths", 2 * (a + b + 2) + 1);
            end
        end

        // R2: start level selection
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                hi = 4'(a + 2); lo = 4'(5 - a); ph = 4'd0; sh = s[0]; fh = ~s[0];
                sync_pulse();
                run_check("R2 start level", 12);
            end
        end

        // R3: every offset, both start and force levels
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                hi = 4'd2; lo = 4'd4; ph = 4'(p); sh = m[0]; fh = m[1];
                sync_pulse();
                run_check("R3 offset", p + 16);
            end
        end

        // R5: request ignored while running
        @(negedge clk);
        hi = 4'd3; lo = 4'd2; ph = 4'd0; sh = 1'b1; fh = 1'b0;
        sync_pulse();
        ign = 1'b1;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            check("R5 ignore sync", int'(clk_out), int'(exp_lvl(n)));
            if (n == 10) sync_req = 1'b1;
            if (n == 30) sync_req = 1'b0;
        end
        ign = 1'b0;
        repeat (4) @(negedge clk);

        // R6: power-down with static level and restart
        pd = 1'b1; fh = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check("R6 power-down level", int'(clk_out), 1);
        end
        fh = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 power-down follows force", int'(clk_out), 0);
        hi = 4'd1; lo = 4'd2; ph = 4'd3; sh = 1'b0;
        pd = 1'b0;
        run_check("R6 restart", 20);

        // R7: bypass passes the input clock
        @(negedge clk) byp = 1'b1; fh = 1'b1;
        for (int n = 0; n < 20; n++) begin
            @(posedge clk) #1;
            check("R7 bypass high", int'(clk_out), 1);
            @(negedge clk) #1;
            check("R7 bypass low", int'(clk_out), 0);
        end
        hi = 4'd4; lo = 4'd0; ph = 4'd0; sh = 1'b1;
        byp = 1'b0;
        run_check("R7 restart after bypass", 15);

        // R8: half-cycle stretch on odd ratios
        for (int c = 0; c < 8; c++) begin
            int h, l, highs, expd;
            @(negedge clk);
            case (c)
                0: begin hi = 4'd0; lo = 4'd1; end
                1: begin hi = 4'd1; lo = 4'd1; end
                2: begin hi = 4'd2; lo = 4'd3; end
                3: begin hi = 4'd4; lo = 4'd4; end
                4: begin hi = 4'd6; lo = 4'd9; end
                5: begin hi = 4'd0; lo = 4'd0; end
                6: begin hi = 4'd15; lo = 4'd14; end
                default: begin hi = 4'd3; lo = 4'd2; end
            endcase
            dcc = (c != 7);
            ph = 4'd0; sh = 1'b1; fh = 1'b0;
            h = int'(hi) + 1; l = int'(lo) + 1;
            sync_pulse();
            repeat (2 * (h + l)) @(negedge clk);
            highs = 0;
            for (int i = 0; i < 2 * (h + l); i++) begin
                @(posedge clk) #1;
                highs += int'(clk_out);
                @(negedge clk) #1;
                highs += int'(clk_out);
            end
            expd = 2 * (2 * h + ((dcc && ((h + l) % 2 == 1)) ? 1 : 0));
            check("R8 duty stretch", highs, expd);
        end
        dcc = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule